// File: doc/BRIEF.md
# Windowed Watchdog Supervisor

This block watches a processor's heartbeat line. The processor proves it is alive by pulling the kick line low once per window. A kick that comes too soon, or a window that ends with no kick, counts as a fault. On a fault the active-low fault output drops for a fixed time, so that the rest of the system can restart the processor. The window then starts again.

All timing comes from one programmed window length, given in clock ticks. The early bound is that length shifted right by four bits, so it is one sixteenth of the window. The fault pulse lasts the window length shifted right by three bits, so one eighth of the window, and never less than one tick. The kick line is an asynchronous input that idles high. It passes through a two-flop synchronizer, and only its falling edges count as kicks.

The watchdog runs only when three things hold at once: the enable input is high, the power sequencer has armed it, and the sequencer's reset is inactive. If any of them drops, the window counter is held at zero and the fault output is released high. This also ends a fault pulse that is still running.

Top module: `win_watchdog`

## Requirements
- R1: After the synchronous reset `rst`, `fault_n` is 1 and the window counter is 0.
- R2: A kick seen while the window count is below `win_len >> 4` is a fault. `fault_n` goes to 0 on the next clock.
- R3: A kick seen while the window count is at least `win_len >> 4` restarts the window count at 0 and does not raise a fault.
- R4: If no kick comes by the time the count reaches `win_len - 1`, a fault is raised. The window count never reaches `win_len`.
- R5: A fault holds `fault_n` at 0 for exactly max(1, `win_len >> 3`) cycles. It then returns to 1 and a new window starts from 0.
- R6: While `wd_enable` is 0, kicks have no effect, `fault_n` is 1 and the counter is held at 0.
- R7: While `seq_rst` is 1, `fault_n` is 1 from the next clock on, even if a fault pulse was running, and the counter is held at 0.
- R8: While `seq_arm` is 0, `fault_n` is 1 and the counter is held at 0.
- R9: A kick is a high-to-low transition of `kick_n` after a two-flop synchronizer. Holding `kick_n` low gives one kick only. Kicks that arrive during a fault pulse are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wd_enable | input | 1 | Turns the watchdog on (1) or off (0) |
| seq_rst | input | 1 | Reset-active indication from the power sequencer, active high |
| seq_arm | input | 1 | Arm condition from the sequencer; the watchdog runs only when this is 1 |
| kick_n | input | 1 | Asynchronous heartbeat input, idles high; a falling edge is a kick |
| win_len | input | 24 | Length of the upper window, in clock ticks |
| fault_n | output | 1 | Registered fault output, active low |

## Verification
The checker checks on every cycle:
- `fault_n` is high and the counter is zero one clock after the watchdog is disabled, unarmed or held in reset.
- The counter stays below the window length.
- No low run of `fault_n` lasts longer than the pulse length.

Some behaviours need the bench's scenarios and its cycle-accurate reference model instead: that a kick before the early bound faults, that a kick inside the window restarts it, that a held-low kick counts once, that kicks are ignored during a pulse, and that a pulse is exactly as long as it should be rather than only no longer.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
  typedef enum logic {
    ST_WATCH = 1'b0,
    ST_PULSE = 1'b1
  } wwd_state_e;
endpackage

// File: rtl/wwd_kick_detect.sv
module wwd_kick_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic kick_n,
  output logic kick_fall
);
  // pipe[0..STAGES-1] synchronize; pipe[STAGES] holds the previous value
  logic [STAGES:0] pipe;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[g] <= 1'b1;
          else     pipe[g] <= kick_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[g] <= 1'b1;
          else     pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  assign kick_fall = pipe[STAGES] & ~pipe[STAGES-1];
endmodule

// File: rtl/wwd_bounds.sv
module wwd_bounds #(
  parameter int WIN_W     = 24,
  parameter int LO_SHIFT  = 4,
  parameter int TMO_SHIFT = 3
) (
  input  logic [WIN_W-1:0] win_len,
  output logic [WIN_W-1:0] lower,
  output logic [WIN_W-1:0] pulse_len
);
  logic [WIN_W-1:0] tmo_raw;

  always_comb begin
    lower     = win_len >> LO_SHIFT;
    tmo_raw   = win_len >> TMO_SHIFT;
    pulse_len = (tmo_raw == '0) ? WIN_W'(1) : tmo_raw;
  end
endmodule

// File: rtl/wwd_core.sv
module wwd_core
  import wwd_pkg::*;
#(
  parameter int WIN_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             kick_fall,
  input  logic [WIN_W-1:0] win_len,
  input  logic [WIN_W-1:0] lower,
  input  logic [WIN_W-1:0] pulse_len,
  output logic             fault_n,
  output logic [WIN_W-1:0] cnt
);
  localparam int EXT_W = WIN_W + 1;

  wwd_state_e       state;
  logic [EXT_W-1:0] cnt_inc;
  logic             late_hit;
  logic             pulse_done;

  always_comb begin
    cnt_inc    = {1'b0, cnt} + EXT_W'(1);
    late_hit   = cnt_inc >= {1'b0, win_len};
    pulse_done = cnt_inc >= {1'b0, pulse_len};
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      state   <= ST_WATCH;
      cnt     <= '0;
      fault_n <= 1'b1;
    end else if (state == ST_PULSE) begin
      if (pulse_done) begin
        state   <= ST_WATCH;
        cnt     <= '0;
        fault_n <= 1'b1;
      end else begin
        cnt <= cnt_inc[WIN_W-1:0];
      end
    end else if (kick_fall) begin
      if (cnt < lower) begin
        state   <= ST_PULSE;
        fault_n <= 1'b0;
      end
      cnt <= '0;
    end else if (late_hit) begin
      state   <= ST_PULSE;
      cnt     <= '0;
      fault_n <= 1'b0;
    end else begin
      cnt <= cnt_inc[WIN_W-1:0];
    end
  end
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog #(
  parameter int WIN_W       = 24,
  parameter int LO_SHIFT    = 4,
  parameter int TMO_SHIFT   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wd_enable,
  input  logic             seq_rst,
  input  logic             seq_arm,
  input  logic             kick_n,
  input  logic [WIN_W-1:0] win_len,
  output logic             fault_n
);
  logic             kick_fall;
  logic             active;
  logic [WIN_W-1:0] lower;
  logic [WIN_W-1:0] pulse_len;
  logic [WIN_W-1:0] cnt_q;

  assign active = wd_enable & seq_arm & ~seq_rst;

  wwd_kick_detect #(.STAGES(SYNC_STAGES)) i_kick (
    .clk(clk), .rst(rst), .kick_n(kick_n), .kick_fall(kick_fall)
  );

  wwd_bounds #(.WIN_W(WIN_W), .LO_SHIFT(LO_SHIFT), .TMO_SHIFT(TMO_SHIFT)) i_bounds (
    .win_len(win_len), .lower(lower), .pulse_len(pulse_len)
  );

  wwd_core #(.WIN_W(WIN_W)) i_core (
    .clk(clk), .rst(rst), .active(active), .kick_fall(kick_fall),
    .win_len(win_len), .lower(lower), .pulse_len(pulse_len),
    .fault_n(fault_n), .cnt(cnt_q)
  );
endmodule

// File: rtl/wwd_checker.sv
module wwd_checker #(
  parameter int WIN_W     = 24,
  parameter int TMO_SHIFT = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             wd_enable,
  input logic             seq_rst,
  input logic             seq_arm,
  input logic [WIN_W-1:0] win_len,
  input logic             fault_n,
  input logic [WIN_W-1:0] cnt
);
  logic [WIN_W:0]   low_run;
  logic [WIN_W-1:0] tmo_c;

  assign tmo_c = ((win_len >> TMO_SHIFT) == '0) ? WIN_W'(1) : (win_len >> TMO_SHIFT);

  always_ff @(posedge clk) begin
    if (rst)           low_run <= '0;
    else if (!fault_n) low_run <= low_run + 1'b1;
    else               low_run <= '0;
  end

  assert_reset_state_R1: assert property (@(posedge clk) rst |=> (fault_n && cnt == '0));

  assert_seq_release_R7: assert property (@(posedge clk) disable iff (rst)
    seq_rst |=> (fault_n && cnt == '0));

  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !wd_enable |=> (fault_n && cnt == '0));

  assert_unarmed_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !seq_arm |=> (fault_n && cnt == '0));

  assert_count_in_window_R4: assert property (@(posedge clk) disable iff (rst)
    (win_len != '0 && $stable(win_len)) |-> (cnt < win_len));

  // R5: a low run never outlasts the pulse length (window length held during pulses)
  assert_pulse_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    !fault_n |-> (low_run < {1'b0, tmo_c}));
endmodule

bind win_watchdog wwd_checker #(.WIN_W(WIN_W), .TMO_SHIFT(TMO_SHIFT)) i_wwd_checker (
  .clk(clk), .rst(rst), .wd_enable(wd_enable), .seq_rst(seq_rst), .seq_arm(seq_arm),
  .win_len(win_len), .fault_n(fault_n), .cnt(cnt_q)
);

// File: tb/test_win_watchdog.sv
`timescale 1ns/1ps
module test_win_watchdog;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wd_enable = 1'b1;
  logic        seq_rst = 1'b0;
  logic        seq_arm = 1'b1;
  logic        kick_n = 1'b1;
  logic [23:0] win_len = 24'd64;
  logic        fault_n;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  string cur_req = "R1";

  // reference model state
  int m_d1 = 1, m_d2 = 1, m_d3 = 1;
  int m_pulse = 0, m_cnt = 0, m_out = 1;

  always #2.5 clk = ~clk;

  win_watchdog i_win_watchdog (
    .clk(clk), .rst(rst), .wd_enable(wd_enable), .seq_rst(seq_rst),
    .seq_arm(seq_arm), .kick_n(kick_n), .win_len(win_len), .fault_n(fault_n)
  );

  always @(posedge clk) begin
    int kev, lo, tmo, up;
    cyc++;
    if (rst) begin
      m_d1 = 1; m_d2 = 1; m_d3 = 1;
      m_pulse = 0; m_cnt = 0; m_out = 1;
    end else begin
      kev = (m_d3 == 1 && m_d2 == 0) ? 1 : 0;
      m_d3 = m_d2; m_d2 = m_d1; m_d1 = int'(kick_n);
      up  = int'(win_len);
      lo  = up / 16;
      tmo = up / 8;
      if (tmo < 1) tmo = 1;
      if (!(wd_enable && seq_arm && !seq_rst)) begin
        m_pulse = 0; m_cnt = 0; m_out = 1;
      end else if (m_pulse == 1) begin
        if (m_cnt + 1 >= tmo) begin m_pulse = 0; m_cnt = 0; m_out = 1; end
        else m_cnt++;
      end else if (kev == 1) begin
        if (m_cnt < lo) begin m_pulse = 1; m_out = 0; end
        m_cnt = 0;
      end else if (m_cnt + 1 >= up) begin
        m_pulse = 1; m_cnt = 0; m_out = 0;
      end else m_cnt++;
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      n_cmp++;
      if (int'(fault_n) != m_out) begin
        n_bad++;
        $display("FAIL %s cycle %0d: fault_n=%0d expected %0d", cur_req, cyc, fault_n, m_out);
      end
    end
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      finish_run();
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic kick(input int low_cycles);
    kick_n = 1'b0;
    wait_cyc(low_cycles);
    kick_n = 1'b1;
  endtask

  task automatic wait_low(input int maxc, output int seen);
    seen = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (!fault_n) begin seen = 1; break; end
    end
  endtask

  initial begin
    int seen, len;
    wait_cyc(4);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", int'(fault_n), 1);

    // R3: kicks inside the window keep fault_n high (win 64, lower 4)
    cur_req = "R3";
    for (int k = 0; k < 6; k++) begin wait_cyc(25); kick(3); end
    chk("R3", int'(fault_n), 1);

    // R2: early kick right after a valid one
    cur_req = "R2";
    wait_cyc(20); kick(2); wait_cyc(1); kick(2);
    wait_low(10, seen);
    chk("R2", seen, 1);

    // R5: pulse length equals 64>>3 = 8
    cur_req = "R5";
    len = 1;
    while (!fault_n && len < 40) begin @(negedge clk); if (!fault_n) len++; end
    chk("R5", len, 8);

    // R4: no kick, late fault
    cur_req = "R4";
    wait_low(80, seen);
    chk("R4", seen, 1);
    wait_cyc(30);

    // R9: held-low kick counts once; kicks during a pulse ignored
    cur_req = "R9";
    wait_cyc(10); kick(120);
    wait_low(80, seen);
    chk("R9", seen, 1);
    kick(2); wait_cyc(1); kick(2);
    wait_cyc(20);

    // R7: sequencer reset cuts a running pulse
    cur_req = "R7";
    wait_low(100, seen);
    seq_rst = 1'b1;
    @(negedge clk);
    chk("R7", int'(fault_n), 1);
    wait_cyc(5); kick(2); wait_cyc(3);
    chk("R7", int'(fault_n), 1);
    seq_rst = 1'b0;
    wait_cyc(30);

    // R6: disabled, early kicks ignored
    cur_req = "R6";
    wd_enable = 1'b0;
    for (int k = 0; k < 10; k++) begin kick(2); wait_cyc(2); end
    wait_cyc(150);
    chk("R6", int'(fault_n), 1);

    // R8: not armed
    cur_req = "R8";
    win_len = 24'd200;
    wd_enable = 1'b1; seq_arm = 1'b0;
    for (int k = 0; k < 5; k++) begin kick(2); wait_cyc(3); end
    wait_cyc(300);
    chk("R8", int'(fault_n), 1);
    seq_arm = 1'b1;

    // larger window: lower 12, pulse 25
    cur_req = "R5";
    wait_low(260, seen);
    chk("R4", seen, 1);
    len = 1;
    while (!fault_n && len < 60) begin @(negedge clk); if (!fault_n) len++; end
    chk("R5", len, 25);
    cur_req = "R3";
    for (int k = 0; k < 4; k++) begin wait_cyc(100); kick(3); end

    // small window: lower 0 (no early fault), pulse 1
    cur_req = "R2";
    wd_enable = 1'b0; win_len = 24'd10; wait_cyc(3); wd_enable = 1'b1;
    kick(2); wait_cyc(1); kick(2); wait_cyc(2);
    cur_req = "R5";
    wait_cyc(60);

    finish_run();
  end
endmodule